// File: doc/BRIEF.md
# Sequential Integer Multiply/Divide Unit

This block performs 32-bit integer multiplication and division, in signed and unsigned forms, over a fixed number of clock cycles per operation. A request is issued by raising `start` for one cycle with an operation code and two operands while the unit is idle. The unit then raises `busy` and ignores any further requests. When the operation finishes, it pulses `done` for one cycle. In that same cycle all results and flags are valid.

Every operation produces two 32-bit words. A multiply returns the low half of its 64-bit product on the primary port and the high half on the auxiliary port. A divide returns the quotient on the primary port and the remainder on the auxiliary port. The auxiliary word is meant for a fixed auxiliary register in the surrounding pipeline. The unit does not write any register file itself.

The unit also reports zero, sign and overflow flags. A divide whose divisor is zero raises a one-cycle exception pulse and leaves every result and flag as it was. Vectoring that exception is left to the surrounding logic.

Top module: `muldiv_unit`

## Requirements
- R1: After reset, `busy`, `done`, `div_zero`, both results and all three flags are 0. A `start` seen while `busy` is low is accepted. `busy` is then high from the next cycle through the cycle in which `done` is high, `done` is high for exactly one cycle, and both are low in the cycle after `done`.
- R2: Operation codes on `op` are 0 signed multiply, 1 unsigned multiply, 2 signed divide, 3 unsigned divide. `done` rises a fixed number of clock edges after the edge that accepts `start`: 13 for both multiplies, 38 for signed divide and 36 for unsigned divide.
- R3: A `start` raised while `busy` is high is ignored. The operation in flight keeps its latency, operation and operands.
- R4: Signed multiply returns the low 32 bits of the 64-bit two's-complement product of `src_a` and `src_b` on `res_lo` and the high 32 bits on `res_hi`.
- R5: Unsigned multiply returns the low and high words of the 64-bit unsigned product on `res_lo` and `res_hi`.
- R6: Signed-multiply overflow is set when the 64-bit product differs from the sign extension of `res_lo`. Unsigned-multiply overflow is set when `res_hi` is nonzero.
- R7: Unsigned divide returns `src_b / src_a` on `res_lo` and the remainder on `res_hi`, and clears overflow.
- R8: Signed divide truncates the quotient toward zero. The remainder carries the sign of the dividend `src_b`. Overflow is cleared except in the case of R9.
- R9: Signed divide of 0x80000000 by 0xFFFFFFFF gives quotient 0x80000000 and remainder 0, and sets overflow.
- R10: A divide with `src_a` equal to 0 pulses `div_zero` together with `done`. `res_lo`, `res_hi` and all flags keep the values they had before the request.
- R11: For every completed operation other than the case in R10, `flag_z` is 1 exactly when `res_lo` is 0, and `flag_s` equals bit 31 of `res_lo`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request strobe, taken only while idle |
| op | input | 2 | Operation code (see R2) |
| src_a | input | 32 | Multiplier, or divisor |
| src_b | input | 32 | Multiplicand, or dividend |
| busy | output | 1 | Operation in progress, through the `done` cycle |
| done | output | 1 | One-cycle completion pulse |
| res_lo | output | 32 | Product low word, or quotient |
| res_hi | output | 32 | Product high word, or remainder |
| flag_z | output | 1 | Primary result is zero |
| flag_s | output | 1 | Primary result is negative |
| flag_ov | output | 1 | Overflow |
| div_zero | output | 1 | Divide-by-zero exception pulse |

## Verification
The assertions assume three things about the inputs:
- reset is applied before the first request;
- `op`, `src_a` and `src_b` are known whenever `start` is high;
- a completion is always preceded by an accepted request, so the latency counter in the checker tracks the same operation as the unit.

The stimulus stays within these assumptions. It drives every input to a defined value during reset and issues requests only on falling edges. It raises its deliberate extra starts, which carry scrambled operation codes and operands, only in the cycles just after acceptance, and it lowers them well before `done` can appear.

// File: rtl/md_pkg.sv
package md_pkg;

    typedef enum logic [1:0] {
        OP_MUL  = 2'd0,
        OP_MULU = 2'd1,
        OP_DIV  = 2'd2,
        OP_DIVU = 2'd3
    } md_op_e;

    typedef struct packed {
        logic zero;
        logic sign;
        logic ovf;
    } md_flags_t;

    // Divides have the upper code bit set.
    function automatic logic op_is_div(input md_op_e op);
        return op[1];
    endfunction

    // Signed variants have the lower code bit clear.
    function automatic logic op_is_signed(input md_op_e op);
        return !op[0];
    endfunction

endpackage

// File: rtl/md_ctrl.sv
module md_ctrl
    import md_pkg::*;
#(
    parameter int MUL_LAT  = 13,
    parameter int DIVU_LAT = 36,
    parameter int DIV_LAT  = 38
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   start,
    input  md_op_e op_in,
    output logic   busy,
    output logic   accept,
    output logic   load_now,
    output logic   done,
    output md_op_e op_q
);

    localparam int MAX_DIV = (DIVU_LAT > DIV_LAT) ? DIVU_LAT : DIV_LAT;
    localparam int MAX_LAT = (MUL_LAT > MAX_DIV) ? MUL_LAT : MAX_DIV;
    localparam int CW      = $clog2(MAX_LAT + 1);

    logic [CW-1:0] cnt;

    function automatic logic [CW-1:0] lat_of(input md_op_e op);
        case (op)
            OP_DIV:  return CW'(DIV_LAT);
            OP_DIVU: return CW'(DIVU_LAT);
            default: return CW'(MUL_LAT);
        endcase
    endfunction

    assign accept   = start && !busy;
    // The last count: outputs are loaded and done rises on the next edge.
    assign load_now = busy && !done && (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            done <= 1'b0;
            cnt  <= '0;
            op_q <= OP_MUL;
        end else begin
            done <= load_now;
            if (accept) begin
                busy <= 1'b1;
                cnt  <= lat_of(op_in) - CW'(1);
                op_q <= op_in;
            end else if (done) begin
                busy <= 1'b0;
            end else if (busy && cnt != '0) begin
                cnt <= cnt - CW'(1);
            end
        end
    end

endmodule

// File: rtl/md_mul.sv
module md_mul #(
    parameter int W = 32
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           load,
    input  logic           sgn,
    input  logic [W-1:0]   mcand,
    input  logic [W-1:0]   mplier,
    output logic [2*W-1:0] product
);

    logic [2*W-1:0] ext_a;
    logic [2*W-1:0] ext_b;

    // Operands are widened once at acceptance; the product settles long
    // before the fixed multiply latency expires.
    always_ff @(posedge clk) begin
        if (rst) begin
            ext_a <= '0;
            ext_b <= '0;
        end else if (load) begin
            ext_a <= {{W{sgn && mcand[W-1]}}, mcand};
            ext_b <= {{W{sgn && mplier[W-1]}}, mplier};
        end
    end

    assign product = ext_a * ext_b;

endmodule

// File: rtl/md_div.sv
module md_div #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic         sgn,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic [W-1:0] quotient,
    output logic [W-1:0] remainder,
    output logic         zero_div,
    output logic         ovf_case
);

    localparam int SW = $clog2(W + 1);

    logic [W-1:0]  mag_d;
    logic [W-1:0]  rem_acc;
    logic [W-1:0]  quo_acc;
    logic [SW-1:0] steps;
    logic          neg_q;
    logic          neg_r;

    logic [W:0] shifted;
    logic [W:0] diff;

    function automatic logic [W-1:0] magnitude(input logic [W-1:0] v, input logic s);
        return (s && v[W-1]) ? (~v + W'(1)) : v;
    endfunction

    assign shifted = {rem_acc, quo_acc[W-1]};
    assign diff    = shifted - {1'b0, mag_d};

    // Restoring division, one quotient bit per cycle on magnitudes.
    always_ff @(posedge clk) begin
        if (rst) begin
            mag_d    <= '0;
            rem_acc  <= '0;
            quo_acc  <= '0;
            steps    <= '0;
            neg_q    <= 1'b0;
            neg_r    <= 1'b0;
            zero_div <= 1'b0;
            ovf_case <= 1'b0;
        end else if (load) begin
            mag_d    <= magnitude(divisor, sgn);
            quo_acc  <= magnitude(dividend, sgn);
            rem_acc  <= '0;
            steps    <= SW'(W);
            neg_q    <= sgn && (dividend[W-1] ^ divisor[W-1]);
            neg_r    <= sgn && dividend[W-1];
            zero_div <= (divisor == '0);
            ovf_case <= sgn && (dividend == {1'b1, {(W-1){1'b0}}}) && (divisor == '1);
        end else if (steps != '0) begin
            steps <= steps - SW'(1);
            if (!diff[W]) begin
                rem_acc <= diff[W-1:0];
                quo_acc <= {quo_acc[W-2:0], 1'b1};
            end else begin
                rem_acc <= shifted[W-1:0];
                quo_acc <= {quo_acc[W-2:0], 1'b0};
            end
        end
    end

    assign quotient  = neg_q ? (~quo_acc + W'(1)) : quo_acc;
    assign remainder = neg_r ? (~rem_acc + W'(1)) : rem_acc;

endmodule

// File: rtl/muldiv_unit.sv
module muldiv_unit
    import md_pkg::*;
#(
    parameter int W        = 32,
    parameter int MUL_LAT  = 13,
    parameter int DIVU_LAT = 36,
    parameter int DIV_LAT  = 38
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [1:0]   op,
    input  logic [W-1:0] src_a,
    input  logic [W-1:0] src_b,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] res_lo,
    output logic [W-1:0] res_hi,
    output logic         flag_z,
    output logic         flag_s,
    output logic         flag_ov,
    output logic         div_zero
);

    md_op_e         op_in;
    md_op_e         op_q;
    logic           accept;
    logic           load_now;
    logic [2*W-1:0] product;
    logic [W-1:0]   quotient;
    logic [W-1:0]   remainder;
    logic           dz_latched;
    logic           ovf_case;

    logic [W-1:0]   next_lo;
    logic [W-1:0]   next_hi;
    md_flags_t      next_flags;
    md_flags_t      flags_q;
    logic           dz_q;

    assign op_in = md_op_e'(op);

    md_ctrl #(
        .MUL_LAT (MUL_LAT),
        .DIVU_LAT(DIVU_LAT),
        .DIV_LAT (DIV_LAT)
    ) ctrl_i (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .op_in   (op_in),
        .busy    (busy),
        .accept  (accept),
        .load_now(load_now),
        .done    (done),
        .op_q    (op_q)
    );

    md_mul #(.W(W)) mul_i (
        .clk    (clk),
        .rst    (rst),
        .load   (accept && !op_is_div(op_in)),
        .sgn    (op_is_signed(op_in)),
        .mcand  (src_b),
        .mplier (src_a),
        .product(product)
    );

    md_div #(.W(W)) div_i (
        .clk      (clk),
        .rst      (rst),
        .load     (accept && op_is_div(op_in)),
        .sgn      (op_is_signed(op_in)),
        .dividend (src_b),
        .divisor  (src_a),
        .quotient (quotient),
        .remainder(remainder),
        .zero_div (dz_latched),
        .ovf_case (ovf_case)
    );

    always_comb begin
        if (op_is_div(op_q)) begin
            next_lo = quotient;
            next_hi = remainder;
        end else begin
            next_lo = product[W-1:0];
            next_hi = product[2*W-1:W];
        end
        next_flags.zero = (next_lo == '0);
        next_flags.sign = next_lo[W-1];
        case (op_q)
            OP_MUL:  next_flags.ovf = (product[2*W-1:W] != {W{product[W-1]}});
            OP_MULU: next_flags.ovf = (product[2*W-1:W] != '0);
            OP_DIV:  next_flags.ovf = ovf_case;
            default: next_flags.ovf = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_lo  <= '0;
            res_hi  <= '0;
            flags_q <= '0;
            dz_q    <= 1'b0;
        end else begin
            dz_q <= 1'b0;
            if (load_now) begin
                if (op_is_div(op_q) && dz_latched) begin
                    dz_q <= 1'b1;
                end else begin
                    res_lo  <= next_lo;
                    res_hi  <= next_hi;
                    flags_q <= next_flags;
                end
            end
        end
    end

    assign flag_z   = flags_q.zero;
    assign flag_s   = flags_q.sign;
    assign flag_ov  = flags_q.ovf;
    assign div_zero = dz_q;

endmodule

// File: rtl/md_checker.sv
module md_checker #(
    parameter int W        = 32,
    parameter int MUL_LAT  = 13,
    parameter int DIVU_LAT = 36,
    parameter int DIV_LAT  = 38
) (
    input logic         clk,
    input logic         rst,
    input logic         start,
    input logic [1:0]   op,
    input logic         busy,
    input logic         done,
    input logic [W-1:0] res_lo,
    input logic [W-1:0] res_hi,
    input logic         flag_z,
    input logic         flag_s,
    input logic         flag_ov,
    input logic         div_zero
);

    localparam int MAX_LAT = (MUL_LAT > DIVU_LAT ? MUL_LAT : DIVU_LAT) > DIV_LAT
                           ? (MUL_LAT > DIVU_LAT ? MUL_LAT : DIVU_LAT) : DIV_LAT;
    localparam int LW = $clog2(MAX_LAT + 2);

    logic [1:0]    op_seen;
    logic [LW-1:0] elapsed;
    logic [LW-1:0] lat_exp;

    always_ff @(posedge clk) begin
        if (rst) begin
            op_seen <= 2'd0;
            elapsed <= '0;
        end else if (start && !busy) begin
            op_seen <= op;
            elapsed <= '0;
        end else if (busy && elapsed != '1) begin
            elapsed <= elapsed + LW'(1);
        end
    end

    always_comb begin
        case (op_seen)
            2'd2:    lat_exp = LW'(DIV_LAT);
            2'd3:    lat_exp = LW'(DIVU_LAT);
            default: lat_exp = LW'(MUL_LAT);
        endcase
    end

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done && !busy); // R1
    AST_DONE_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
        done |-> busy); // R1
    AST_BUSY_HELD: assert property (@(posedge clk) disable iff (rst)
        busy && !done |=> busy); // R1
    AST_FIXED_LATENCY: assert property (@(posedge clk) disable iff (rst)
        done |-> elapsed == lat_exp); // R2
    AST_DZ_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
        div_zero |-> done && op_seen[1]); // R10
    AST_DZ_KEEPS_OUTPUTS: assert property (@(posedge clk) disable iff (rst)
        div_zero |-> $stable(res_lo) && $stable(res_hi) && $stable(flag_z)
                     && $stable(flag_s) && $stable(flag_ov)); // R10
    AST_MULU_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        done && op_seen == 2'd1 |-> flag_ov == (res_hi != '0)); // R6
    AST_DIVU_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        done && !div_zero && op_seen == 2'd3 |-> !flag_ov); // R7
    AST_ZERO_SIGN: assert property (@(posedge clk) disable iff (rst)
        done && !div_zero |-> flag_z == (res_lo == '0) && flag_s == res_lo[W-1]); // R11

endmodule

bind muldiv_unit md_checker #(
    .W       (W),
    .MUL_LAT (MUL_LAT),
    .DIVU_LAT(DIVU_LAT),
    .DIV_LAT (DIV_LAT)
) chk_i (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .op      (op),
    .busy    (busy),
    .done    (done),
    .res_lo  (res_lo),
    .res_hi  (res_hi),
    .flag_z  (flag_z),
    .flag_s  (flag_s),
    .flag_ov (flag_ov),
    .div_zero(div_zero)
);

// File: tb/muldiv_unit_tb_top.sv
module muldiv_unit_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int W          = 32;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic [1:0]   op = 2'd0;
    logic [W-1:0] src_a = '0;
    logic [W-1:0] src_b = '0;
    logic         busy, done, flag_z, flag_s, flag_ov, div_zero;
    logic [W-1:0] res_lo, res_hi;

    int n_cmp = 0;
    int n_bad = 0;

    // Last valid outputs the model expects to be held.
    logic [W-1:0] m_lo = '0;
    logic [W-1:0] m_hi = '0;
    logic         m_z = 1'b0;
    logic         m_s = 1'b0;
    logic         m_ov = 1'b0;

    muldiv_unit dut_i (
        .clk(clk), .rst(rst), .start(start), .op(op),
        .src_a(src_a), .src_b(src_b), .busy(busy), .done(done),
        .res_lo(res_lo), .res_hi(res_hi), .flag_z(flag_z),
        .flag_s(flag_s), .flag_ov(flag_ov), .div_zero(div_zero)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic int lat_of(input logic [1:0] o);
        case (o)
            2'd2:    return 38;
            2'd3:    return 36;
            default: return 13;
        endcase
    endfunction

    // Reference model; returns 1 when a zero divisor blocks the update.
    function automatic logic model(input logic [1:0] o, input logic [W-1:0] a,
                                   input logic [W-1:0] b);
        longint       sp;
        logic [63:0]  up;
        longint       n, d;
        logic [W-1:0] lo, hi;
        logic         ov;
        case (o)
            2'd0: begin
                sp = longint'($signed(a)) * longint'($signed(b));
                lo = sp[31:0]; hi = sp[63:32];
                ov = (sp != longint'($signed(lo)));
            end
            2'd1: begin
                up = {32'd0, a} * {32'd0, b};
                lo = up[31:0]; hi = up[63:32];
                ov = (hi != 0);
            end
            2'd2: begin
                if (a == 0) return 1'b1;
                n = longint'($signed(b)); d = longint'($signed(a));
                sp = n / d; lo = sp[31:0];
                sp = n % d; hi = sp[31:0];
                ov = (b == 32'h8000_0000) && (a == 32'hFFFF_FFFF);
            end
            default: begin
                if (a == 0) return 1'b1;
                lo = b / a; hi = b % a; ov = 1'b0;
            end
        endcase
        m_lo = lo; m_hi = hi; m_ov = ov;
        m_z = (lo == 0); m_s = lo[31];
        return 1'b0;
    endfunction

    task automatic run_op(input logic [1:0] o, input logic [W-1:0] a,
                          input logic [W-1:0] b, input int noise);
        int    lat = 0;
        logic  dz;
        string rq_res;
        string rq_ov;
        @(negedge clk);
        start = 1'b1; op = o; src_a = a; src_b = b;
        for (int i = 0; i < 100; i++) begin
            @(posedge clk);
            @(negedge clk);
            lat++;
            if (lat <= noise) begin
                start = 1'b1; op = ~o; src_a = $urandom; src_b = $urandom;
            end else begin
                start = 1'b0;
            end
            if (done) break;
        end
        dz = model(o, a, b);
        check(noise > 0 ? "R3" : "R2", "latency", 64'(lat - 1), 64'(lat_of(o)));
        case (o)
            2'd0:    rq_res = "R4";
            2'd1:    rq_res = "R5";
            2'd2:    rq_res = (b == 32'h8000_0000 && a == 32'hFFFF_FFFF) ? "R9" : "R8";
            default: rq_res = "R7";
        endcase
        rq_ov = o[1] ? rq_res : "R6";
        if (o[1] && a == 0) begin
            rq_res = "R10"; rq_ov = "R10";
        end
        check(rq_res, "results", {res_hi, res_lo}, {m_hi, m_lo});
        check(rq_ov, "overflow", 64'(flag_ov), 64'(m_ov));
        check(dz ? "R10" : "R11", "zero/sign", {62'd0, flag_z, flag_s}, {62'd0, m_z, m_s});
        check("R10", "div_zero", 64'(div_zero), 64'(dz));
        @(negedge clk);
        check("R1", "idle after done", {62'd0, busy, done}, 64'd0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [1:0]   ro;
        logic [W-1:0] ra, rb;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1", "reset ctl", {61'd0, busy, done, div_zero}, 64'd0);
        check("R1", "reset res", {res_hi, res_lo}, 64'd0);
        check("R1", "reset flags", {61'd0, flag_z, flag_s, flag_ov}, 64'd0);

        run_op(2'd0, 32'd7, 32'hFFFF_FFFD, 0);
        run_op(2'd0, 32'h0001_0000, 32'h0001_0000, 0);
        run_op(2'd0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 3);
        run_op(2'd0, 32'd0, 32'h1234_5678, 0);
        run_op(2'd1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0);
        run_op(2'd1, 32'd3, 32'd5, 2);
        run_op(2'd3, 32'd7, 32'd100, 0);
        run_op(2'd3, 32'hFFFF_FFFF, 32'd5, 0);
        run_op(2'd3, 32'd0, 32'd99, 0);
        run_op(2'd2, 32'd2, 32'hFFFF_FFF9, 4);
        run_op(2'd2, 32'hFFFF_FFFE, 32'd7, 0);
        run_op(2'd2, 32'hFFFF_FFFF, 32'h8000_0000, 0);
        run_op(2'd2, 32'd0, 32'hDEAD_BEEF, 0);
        run_op(2'd2, 32'd1, 32'h8000_0000, 0);

        for (int k = 0; k < 60; k++) begin
            ro = 2'($urandom);
            ra = $urandom;
            rb = $urandom;
            if (($urandom % 8) == 0) ra = W'($urandom % 4);
            if (($urandom % 6) == 0) rb = W'($urandom % 16) - W'(8);
            run_op(ro, ra, rb, int'($urandom % 3));
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule